// File: doc/BRIEF.md
# Magnitude Threshold Detector with Dwell

This block watches a stream of unsigned sample magnitudes that arrive one per sample-valid strobe and turns them into level flags for an automatic gain loop. An over-range flag reacts to a single sample above a fine upper limit. A coarse over-range flag compares each sample against one of eight fixed levels chosen by a 3-bit code.

On the low side, the block raises an under-range flag and a matching gain-increase request only when the signal stays under a fine lower limit for a programmable number of consecutive samples. This dwell keeps short dips from pumping the gain. An enable input gates all the flags and drives an output-enable signal, so that pad logic downstream can release its pins.

All flags are registered. They update on the clock edge that takes in a valid sample and hold their value between strobes.

Top module: `mag_thresh_det`

## Requirements
- R1: On a clock edge with `smp_vld` and `en` high, `up_flag` takes the value (`smp_mag` > `up_thr`), using a strict compare. It is visible after that edge.
- R2: With `dwell` = D > 0, `lo_flag` rises on the edge of the D-th consecutive valid sample whose magnitude is strictly below `lo_thr`. After D-1 such samples it is still low.
- R3: With `dwell` = 0, a single valid sample below `lo_thr` raises `lo_flag` on its edge.
- R4: A valid sample with magnitude at or above `lo_thr` clears the dwell count, and `lo_flag` is low after that edge.
- R5: `gain_up` always equals `lo_flag`.
- R6: On a valid edge, `crs_flag` takes the value (`smp_mag` >= 2^(13-n) - 1), where n is the value of `crs_code`. Code 0 selects 8191 and code 7 selects 63.
- R7: On an edge with `en` low, `out_en`, `up_flag`, `crs_flag`, `lo_flag` and `gain_up` all go to 0, and the dwell count restarts. `out_en` follows `en` with one register delay.
- R8: On an edge with `smp_vld` low and `en` high, every flag keeps its value.
- R9: After a synchronous reset, every output is 0.
- R10: The dwell count saturates instead of wrapping. With `dwell` = 65535, the flag rises on the 65535-th low sample and stays high for the samples that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Detector enable |
| smp_vld | input | 1 | Sample-valid strobe |
| smp_mag | input | 13 | Sample magnitude |
| up_thr | input | 13 | Fine upper limit |
| lo_thr | input | 13 | Fine lower limit |
| dwell | input | 16 | Number of low samples required before the under-range flag |
| crs_code | input | 3 | Coarse level select |
| out_en | output | 1 | Output enable for the flag pins |
| up_flag | output | 1 | Fine over-range flag |
| crs_flag | output | 1 | Coarse over-range flag |
| lo_flag | output | 1 | Under-range flag, qualified by the dwell |
| gain_up | output | 1 | Gain-increase request |

## Verification
The over-range compare and the under-range dwell can act on the same sample when the upper limit is set below the lower limit. In that case one magnitude can raise `up_flag` while it also completes or restarts a low run. The random phase chooses limits that overlap in this way on purpose and drives runs of low samples with strobe gaps between them. A bench model computes both flags for every sample and checks them in the cycle after the edge, so a design that lets one path disturb the other fails the check.

// File: rtl/mag_thresh_pkg.sv
package mag_thresh_pkg;

    localparam int MAG_W   = 13;
    localparam int DWELL_W = 16;
    localparam int CRS_W   = 3;

    typedef logic [MAG_W-1:0]   mag_t;
    typedef logic [DWELL_W-1:0] dwell_t;
    typedef logic [CRS_W-1:0]   crs_t;

    typedef struct packed {
        logic up;
        logic crs;
    } hit_t;

    typedef struct packed {
        logic oe;
        logic up;
        logic crs;
    } out_reg_t;

    // coarse level for code n is 2^(MAG_W-n) - 1
    function automatic mag_t coarse_level(input crs_t code);
        logic [MAG_W:0] one_hot;
        logic [MAG_W:0] lvl;
        one_hot = '0;
        one_hot[MAG_W - int'(code)] = 1'b1;
        lvl = one_hot - 1'b1;
        return lvl[MAG_W-1:0];
    endfunction

endpackage

// File: rtl/mt_level_cmp.sv
module mt_level_cmp
    import mag_thresh_pkg::*;
(
    input  mag_t mag,
    input  mag_t up_thr,
    input  crs_t crs_code,
    output hit_t hit
);
    localparam int N_CODES = 1 << CRS_W;

    mag_t lvl_tab [N_CODES];

    genvar gi;
    generate
        for (gi = 0; gi < N_CODES; gi++) begin : g_lvl
            assign lvl_tab[gi] = coarse_level(crs_t'(gi));
        end
    endgenerate

    always_comb begin
        hit.up  = mag > up_thr;
        hit.crs = mag >= lvl_tab[crs_code];
    end

endmodule

// File: rtl/mt_dwell.sv
module mt_dwell
    import mag_thresh_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   step,
    input  logic   low,
    input  dwell_t dwell,
    output logic   lo_flag
);
    localparam dwell_t CNT_MAX = '1;

    dwell_t cnt_q;
    dwell_t cnt_nxt;
    logic   flag_q;

    always_comb begin
        cnt_nxt = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (step) begin
            if (low) begin
                cnt_q  <= cnt_nxt;
                flag_q <= cnt_nxt >= dwell;
            end else begin
                cnt_q  <= '0;
                flag_q <= 1'b0;
            end
        end
    end

    assign lo_flag = flag_q;

    // R10
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && step && low && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

    // R4
    high_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !low) |=> (cnt_q == '0 && !flag_q));

endmodule

// File: rtl/mag_thresh_det.sv
module mag_thresh_det
    import mag_thresh_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        smp_vld,
    input  logic [12:0] smp_mag,
    input  logic [12:0] up_thr,
    input  logic [12:0] lo_thr,
    input  logic [15:0] dwell,
    input  logic [2:0]  crs_code,
    output logic        out_en,
    output logic        up_flag,
    output logic        crs_flag,
    output logic        lo_flag,
    output logic        gain_up
);
    hit_t     hit;
    out_reg_t oreg_q;
    logic     lo_raw;
    logic     step;
    logic     is_low;

    assign step   = smp_vld && en;
    assign is_low = smp_mag < lo_thr;

    mt_level_cmp u_cmp (
        .mag      (smp_mag),
        .up_thr   (up_thr),
        .crs_code (crs_code),
        .hit      (hit)
    );

    mt_dwell u_dwell (
        .clk     (clk),
        .rst     (rst),
        .clr     (!en),
        .step    (step),
        .low     (is_low),
        .dwell   (dwell),
        .lo_flag (lo_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            oreg_q <= '0;
        end else if (!en) begin
            oreg_q <= '0;
        end else begin
            oreg_q.oe <= 1'b1;
            if (smp_vld) begin
                oreg_q.up  <= hit.up;
                oreg_q.crs <= hit.crs;
            end
        end
    end

    assign out_en   = oreg_q.oe;
    assign up_flag  = oreg_q.up;
    assign crs_flag = oreg_q.crs;
    assign lo_flag  = lo_raw;
    assign gain_up  = lo_raw;

    // R1
    up_strict_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> up_flag == ($past(smp_mag) > $past(up_thr)));

    // R7
    disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!out_en && !up_flag && !crs_flag && !lo_flag && !gain_up));

    // R5
    gain_match_chk: assert property (@(posedge clk) disable iff (rst)
        gain_up == lo_flag);

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !smp_vld) |=> ($stable(up_flag) && $stable(crs_flag) && $stable(lo_flag)));

    // R4
    lo_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !is_low) |=> !lo_flag);

endmodule

// File: tb/mag_thresh_det_bench.sv
module mag_thresh_det_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        smp_vld = 1'b0;
    logic [12:0] smp_mag = '0;
    logic [12:0] up_thr = '0;
    logic [12:0] lo_thr = '0;
    logic [15:0] dwell = '0;
    logic [2:0]  crs_code = '0;
    logic        out_en, up_flag, crs_flag, lo_flag, gain_up;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    // bench model state
    bit          m_oe, m_up, m_crs, m_lo;
    int unsigned m_run;

    always #5 clk = ~clk;

    mag_thresh_det u_mag_thresh_det (
        .clk(clk), .rst(rst), .en(en), .smp_vld(smp_vld), .smp_mag(smp_mag),
        .up_thr(up_thr), .lo_thr(lo_thr), .dwell(dwell), .crs_code(crs_code),
        .out_en(out_en), .up_flag(up_flag), .crs_flag(crs_flag),
        .lo_flag(lo_flag), .gain_up(gain_up)
    );

    function automatic int unsigned crs_lvl(input int unsigned code);
        return (32'd1 << (13 - code)) - 1;
    endfunction

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_oe = 0; m_up = 0; m_crs = 0; m_lo = 0; m_run = 0;
        end else if (!en) begin
            m_oe = 0; m_up = 0; m_crs = 0; m_lo = 0; m_run = 0;
        end else begin
            m_oe = 1;
            if (smp_vld) begin
                m_up  = smp_mag > up_thr;
                m_crs = smp_mag >= crs_lvl(crs_code);
                if (smp_mag < lo_thr) begin
                    if (m_run < 65535) m_run++;
                    m_lo = m_run >= dwell;
                end else begin
                    m_run = 0;
                    m_lo  = 0;
                end
            end
        end
    endtask

    task automatic check_all();
        check("R7", "out_en",   out_en,   m_oe);
        check("R1", "up_flag",  up_flag,  m_up);
        check("R6", "crs_flag", crs_flag, m_crs);
        check("R2", "lo_flag",  lo_flag,  m_lo);
        check("R5", "gain_up",  gain_up,  m_lo);
    endtask

    // called at negedge: drive, take one edge, check at next negedge
    task automatic sample(input bit v, input int unsigned m);
        smp_vld = v;
        smp_mag = 13'(m);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #1900000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        sample(0, 0);
        // R9: reset state
        check("R9", "out_en reset", out_en, 1'b0);
        check("R9", "lo_flag reset", lo_flag, 1'b0);
        rst = 0;
        en = 1;
        up_thr = 13'd4000; lo_thr = 13'd100; dwell = 16'd5; crs_code = 3'd2;
        sample(0, 0);

        // R2: dwell boundary, 4 low samples then the 5th
        for (int i = 0; i < 4; i++) sample(1, 50);
        check("R2", "D-1 low samples", lo_flag, 1'b0);
        sample(1, 50);
        check("R2", "D low samples", lo_flag, 1'b1);
        // R8: idle strobes hold
        sample(0, 8000);
        sample(0, 8000);
        check("R8", "hold lo_flag", lo_flag, 1'b1);
        // R4: sample at the limit clears
        sample(1, 100);
        check("R4", "at-limit clears", lo_flag, 1'b0);
        // R1: strict compare at the limit, and above
        sample(1, 4000);
        check("R1", "equal not over", up_flag, 1'b0);
        sample(1, 4001);
        check("R1", "over by one", up_flag, 1'b1);
        // R6: code 2 -> 2047
        sample(1, 2046);
        check("R6", "below coarse", crs_flag, 1'b0);
        sample(1, 2047);
        check("R6", "at coarse", crs_flag, 1'b1);
        crs_code = 3'd7;
        sample(1, 63);
        check("R6", "code7 at 63", crs_flag, 1'b1);
        crs_code = 3'd0;
        sample(1, 8190);
        check("R6", "code0 at 8190", crs_flag, 1'b0);
        // R3: dwell zero
        dwell = 16'd0;
        sample(1, 0);
        check("R3", "dwell zero first low", lo_flag, 1'b1);
        // R7: disable clears and restarts history
        dwell = 16'd3;
        sample(1, 0); sample(1, 0);
        en = 0;
        sample(1, 0);
        check("R7", "disabled out_en", out_en, 1'b0);
        en = 1;
        sample(1, 0);
        check("R7", "history restarted", lo_flag, 1'b0);
        sample(1, 0); sample(1, 0);
        check("R7", "three after re-enable", lo_flag, 1'b1);

        // random phase: overlapping limits so upper and lower act together
        for (int blk = 0; blk < 40; blk++) begin
            up_thr   = 13'($urandom_range(0, 800));
            lo_thr   = 13'($urandom_range(200, 1200));
            dwell    = 16'($urandom_range(0, 12));
            crs_code = 3'($urandom_range(0, 7));
            en       = ($urandom_range(0, 15) != 0);
            for (int k = 0; k < 60; k++) begin
                sample($urandom_range(0, 3) != 0,
                       ($urandom_range(0, 9) == 0) ? $urandom_range(0, 8191)
                                                  : $urandom_range(0, 1400));
            end
        end

        // R10: saturation at full dwell
        en = 1; up_thr = 13'd8191; lo_thr = 13'd10; dwell = 16'hFFFF; crs_code = 3'd0;
        sample(1, 20);
        for (int i = 0; i < 65534; i++) begin
            smp_vld = 1; smp_mag = 13'd1;
            @(posedge clk);
            model_edge();
        end
        @(negedge clk);
        check("R10", "65534 low samples", lo_flag, 1'b0);
        sample(1, 1);
        check("R10", "65535 low samples", lo_flag, 1'b1);
        for (int i = 0; i < 5; i++) sample(1, 1);
        check("R10", "stays after saturation", lo_flag, 1'b1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule